// File: doc/BRIEF.md
# Timer-Triggered Converter Sample Capture

This block turns a periodic trigger pulse into one conversion on an external successive-approximation converter and files each result into an on-chip circular buffer. On a trigger it latches the requested channel, selects that channel's pad with a one-hot enable, waits for the converter to report idle, and drives a low-then-high start handshake. It then waits for the done indication and captures the 12-bit result.

Each captured result is written at the current write index, and the index moves forward by one. When the index passes the last entry it returns to zero. A single-cycle buffer-full pulse and a sticky full flag then tell the consumer that a complete block of samples is ready. A trigger that arrives while a conversion is still running is dropped, and a sticky overrun flag records it.

The consumer reads entries through a valid/ready request channel and a valid/ready response channel. The read request is accepted when `rd_req_ready` is high. A response stays valid, with its data held, until `rd_rsp_ready` is seen high. While a response is waiting and `rd_rsp_ready` is low, no new request is accepted.

Top module: `adc_capture_ctrl`

## Requirements
- R1: `adc_en` is all-zero while no conversion is in progress. From the cycle after an accepted trigger until the capture, it is one-hot, with bit `chan` set as sampled on the trigger cycle.
- R2: `adc_start` does not rise until `adc_busy` has been sampled low after the pad was selected. While `adc_busy` stays high, the start bit stays low.
- R3: Before `adc_start` rises, it is held low for at least one full clock while the pad enable is already driven.
- R4: Once `adc_done` is sampled high with `adc_start` high, `adc_start` returns low on the next cycle. The result on `adc_data` at that same edge is the one captured.
- R5: A stored entry is 16 bits wide: bits 11:0 hold the captured result and bits 15:12 are zero.
- R6: After reset the write index is 0. Each captured result is stored at the current index, which then advances by exactly one, so the n-th capture after reset lands at address n.
- R7: After 1000 captures (the default depth) the index returns to 0 and `full_pulse` is high for exactly one cycle, starting one cycle after the done edge of the last capture. The next capture lands at address 0.
- R8: `full_flag` is set by `full_pulse` and holds until `full_ack` is high on a cycle with no new pulse. A pulse and an acknowledge in the same cycle leave it set.
- R9: A trigger that arrives while a conversion is in progress starts no conversion and writes no entry. It sets `ovr_flag`, which stays set until `ovr_clr`.
- R10: The read response appears on the cycle after the request is accepted. It is held stable while `rd_rsp_ready` is low, and during that time `rd_req_ready` is low. An address of 1000 or more returns zero.
- R11: After reset, `adc_start` is low, `adc_en` is zero, both flags are clear, `rd_rsp_valid` is low and `rd_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Timer trigger pulse; one conversion per accepted pulse |
| chan | input | 3 | Channel to convert, sampled with the trigger |
| adc_en | output | 8 | One-hot pad enable toward the converter |
| adc_busy | input | 1 | Converter reports a measurement in progress |
| adc_start | output | 1 | Conversion start bit |
| adc_done | input | 1 | Converter reports the result is ready |
| adc_data | input | 12 | Conversion result |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted this cycle when high |
| rd_addr | input | 10 | Buffer address to read |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_ready | input | 1 | Consumer takes the response |
| rd_rsp_data | output | 16 | Read response data |
| full_pulse | output | 1 | One-cycle pulse when the buffer wraps |
| full_flag | output | 1 | Sticky buffer-full status |
| full_ack | input | 1 | Clears `full_flag` |
| ovr_flag | output | 1 | Sticky trigger-overrun status |
| ovr_clr | input | 1 | Clears `ovr_flag` |

## Verification
The handshake assertions assume a converter that behaves: it raises `adc_done` only while `adc_start` is high, keeps it high until start drops, and holds `adc_data` steady while done is high. The bench converter model follows these rules. It raises done a chosen number of cycles after start, drops done when start falls, and models the busy time as a countdown that the bench sets before each trigger. The read-port assertion assumes that the consumer does not change its mind about a request while `rd_req_ready` is low. The bench keeps each request to a single accepted cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_LOW  = 2'd2,
    SEQ_HIGH = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cap_sticky.sv
module cap_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8, R9: a set event always leaves the flag high
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R8, R9: a clear without set drops it
  assert_sticky_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/cap_seq.sv
module cap_seq #(
  parameter int CHAN_N = 8,
  parameter int CHAN_W = 3,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [CHAN_W-1:0] chan,
  output logic [CHAN_N-1:0] adc_en,
  input  logic              adc_busy,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data,
  output logic              cap_valid,
  output logic [RES_W-1:0]  cap_data,
  output logic              overrun_evt
);
  import cap_pkg::*;

  seq_state_e        state;
  logic [CHAN_W-1:0] chan_q;
  logic              active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      chan_q    <= '0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      cap_valid <= 1'b0;
      case (state)
        SEQ_IDLE: if (trig) begin
          chan_q <= chan;
          state  <= SEQ_WAIT;
        end
        SEQ_WAIT: if (!adc_busy) state <= SEQ_LOW;
        SEQ_LOW:  state <= SEQ_HIGH;
        SEQ_HIGH: if (adc_done) begin
          cap_valid <= 1'b1;
          cap_data  <= adc_data;
          state     <= SEQ_IDLE;
        end
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assign active      = (state != SEQ_IDLE);
  assign adc_start   = (state == SEQ_HIGH);
  assign overrun_evt = trig && active;

  for (genvar i = 0; i < CHAN_N; i++) begin : g_pad
    assign adc_en[i] = active && (chan_q == CHAN_W'(i));
  end

  assert_en_onehot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_en));
  assert_en_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT) |-> $onehot(adc_en));
  assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_WAIT && adc_busy) |=> !adc_start);
  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_start) |-> ($past(adc_en) == adc_en && $past(adc_en) != '0));
  assert_start_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && adc_done) |=> (!adc_start && cap_valid));
endmodule

// File: rtl/cap_ring.sv
module cap_ring #(
  parameter int DEPTH    = 1000,
  parameter int RES_W    = 12,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_valid,
  input  logic [RES_W-1:0]    cap_data,
  output logic                full_pulse,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  input  logic [IDX_W-1:0]    rd_addr,
  output logic                rd_rsp_valid,
  input  logic                rd_rsp_ready,
  output logic [SAMPLE_W-1:0] rd_rsp_data
);
  localparam int MEM_N = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] LIMIT    = IDX_W'(DEPTH);

  logic [SAMPLE_W-1:0] mem [MEM_N];
  logic [IDX_W-1:0]    wr_idx;
  logic                req_fire;

  always_ff @(posedge clk) begin
    if (cap_valid) mem[wr_idx] <= {{(SAMPLE_W-RES_W){1'b0}}, cap_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx     <= '0;
      full_pulse <= 1'b0;
    end else begin
      full_pulse <= 1'b0;
      if (cap_valid) begin
        if (wr_idx == LAST_IDX) begin
          wr_idx     <= '0;
          full_pulse <= 1'b1;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end

  assign rd_req_ready = !rd_rsp_valid || rd_rsp_ready;
  assign req_fire     = rd_req_valid && rd_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else if (req_fire) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= (rd_addr < LIMIT) ? mem[rd_addr] : '0;
    end else if (rd_rsp_ready) begin
      rd_rsp_valid <= 1'b0;
    end
  end

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx <= LAST_IDX);
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && wr_idx != LAST_IDX) |=> wr_idx == $past(wr_idx) + 1'b1);
  assert_pulse_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_pulse |-> (wr_idx == '0 && $past(cap_valid)));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_pulse |=> !full_pulse);
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_data)));
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int CHAN_N   = 8,
  parameter int RES_W    = 12,
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 1000,
  localparam int CHAN_W  = $clog2(CHAN_N),
  localparam int IDX_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig,
  input  logic [CHAN_W-1:0]   chan,
  output logic [CHAN_N-1:0]   adc_en,
  input  logic                adc_busy,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [RES_W-1:0]    adc_data,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  input  logic [IDX_W-1:0]    rd_addr,
  output logic                rd_rsp_valid,
  input  logic                rd_rsp_ready,
  output logic [SAMPLE_W-1:0] rd_rsp_data,
  output logic                full_pulse,
  output logic                full_flag,
  input  logic                full_ack,
  output logic                ovr_flag,
  input  logic                ovr_clr
);
  logic             cap_valid;
  logic [RES_W-1:0] cap_data;
  logic             overrun_evt;

  cap_seq #(.CHAN_N(CHAN_N), .CHAN_W(CHAN_W), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .chan(chan),
    .adc_en(adc_en), .adc_busy(adc_busy), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data),
    .cap_valid(cap_valid), .cap_data(cap_data), .overrun_evt(overrun_evt)
  );

  cap_ring #(.DEPTH(DEPTH), .RES_W(RES_W), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .full_pulse(full_pulse),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data)
  );

  cap_sticky u_full (.clk(clk), .rst_n(rst_n), .set(full_pulse), .clr(full_ack), .q(full_flag));
  cap_sticky u_ovr  (.clk(clk), .rst_n(rst_n), .set(overrun_evt), .clr(ovr_clr), .q(ovr_flag));

  assert_ovr_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && adc_start && !adc_done) |=> adc_start);
endmodule

// File: tb/tb_adc_capture_ctrl.sv
module tb_adc_capture_ctrl;
  localparam int NV = 8;
  // packed vector: [31:28] chan, [27:16] data, [15:8] busy cycles, [7:0] done delay
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 12'h000, 8'd0, 8'd1},
    {4'd7, 12'hFFF, 8'd3, 8'd2},
    {4'd3, 12'hA5C, 8'd5, 8'd1},
    {4'd1, 12'h801, 8'd2, 8'd6},
    {4'd6, 12'h3C3, 8'd0, 8'd3},
    {4'd2, 12'h7FF, 8'd9, 8'd1},
    {4'd5, 12'h123, 8'd4, 8'd4},
    {4'd4, 12'hE0E, 8'd1, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [2:0] chan = '0;
  logic [7:0] adc_en;
  logic adc_busy, adc_start, adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic rd_req_valid = 1'b0, rd_req_ready, rd_rsp_valid, rd_rsp_ready = 1'b1;
  logic [9:0] rd_addr = '0;
  logic [15:0] rd_rsp_data;
  logic full_pulse, full_flag, full_ack = 1'b0, ovr_flag, ovr_clr = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0, busy_until = 0, cur_dly = 1, wait_cnt = 0;
  int rise_cyc = 0, low_cnt = 0, low_at_rise = 0, r4_bad = 0, pulse_cnt = 0, pulse_run = 0, pulse_max = 0;
  logic [7:0] en_at_rise = '0;
  logic start_seen = 1'b0, done_seen = 1'b0, finished = 1'b0;
  logic [11:0] model_data = '0;
  int exp_idx = 0;
  logic [15:0] got;

  always #4 clk = ~clk;

  adc_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .chan(chan), .adc_en(adc_en),
    .adc_busy(adc_busy), .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .full_pulse(full_pulse), .full_flag(full_flag), .full_ack(full_ack),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
  );

  assign adc_busy = (cyc < busy_until);

  // converter model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    adc_data <= model_data;
    if (!adc_start) begin
      adc_done <= 1'b0;
      wait_cnt <= 0;
    end else begin
      wait_cnt <= wait_cnt + 1;
      adc_done <= (wait_cnt + 1 >= cur_dly);
    end
  end

  // monitor between edges
  always @(negedge clk) begin
    if (adc_start && !start_seen) begin
      rise_cyc    = cyc;
      en_at_rise  = adc_en;
      low_at_rise = low_cnt;
    end
    if (done_seen && adc_start) r4_bad = r4_bad + 1;
    done_seen  = adc_start && adc_done;
    start_seen = adc_start;
    if (adc_en != '0 && !adc_start) low_cnt = low_cnt + 1;
    else if (adc_en == '0) low_cnt = 0;
    if (full_pulse) begin
      pulse_run = pulse_run + 1;
      if (pulse_run == 1) pulse_cnt = pulse_cnt + 1;
      if (pulse_run > pulse_max) pulse_max = pulse_run;
    end else pulse_run = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [2:0] c, input logic [11:0] d, input int busy, input int dly);
    @(negedge clk);
    chan = c; model_data = d; cur_dly = dly; busy_until = cyc + busy; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (busy + dly + 8) @(negedge clk);
    exp_idx = (exp_idx + 1) % 1000;
  endtask

  task automatic read(input int a, output logic [15:0] d);
    @(negedge clk);
    rd_req_valid = 1'b1; rd_addr = 10'(a);
    @(negedge clk);
    rd_req_valid = 1'b0;
    check(rd_rsp_valid == 1'b1, "R10 rsp valid", int'(rd_rsp_valid), 1);
    d = rd_rsp_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(adc_start == 1'b0, "R11 start", int'(adc_start), 0);
    check(adc_en == '0, "R11 en", int'(adc_en), 0);
    check(!full_flag && !ovr_flag, "R11 flags", int'({full_flag, ovr_flag}), 0);
    check(!rd_rsp_valid && rd_req_ready, "R11 read port", int'({rd_rsp_valid, rd_req_ready}), 1);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [2:0] c; logic [11:0] d; int b, dl, at;
      c = VEC[i][30:28]; d = VEC[i][27:16]; b = int'(VEC[i][15:8]); dl = int'(VEC[i][7:0]);
      at = exp_idx;
      convert(c, d, b, dl);
      check(en_at_rise == (8'd1 << c), "R1 one-hot pad", int'(en_at_rise), int'(8'd1 << c));
      check(adc_en == '0, "R1 idle pads off", int'(adc_en), 0);
      if (b >= 2) check(rise_cyc >= busy_until + 2, "R2 start after idle", rise_cyc, busy_until + 2);
      check(low_at_rise >= 1, "R3 start low first", low_at_rise, 1);
      read(at, got);
      check(got == {4'h0, d}, "R5 R6 stored entry", int'(got), int'({4'h0, d}));
    end
    check(r4_bad == 0, "R4 start drops after done", r4_bad, 0);

    // overrun: second trigger while busy
    begin
      int at;
      at = exp_idx;
      @(negedge clk);
      chan = 3'd2; model_data = 12'h5A5; cur_dly = 1; busy_until = cyc + 20; trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      repeat (4) @(negedge clk);
      chan = 3'd6; trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      check(ovr_flag == 1'b1, "R9 overrun flag", int'(ovr_flag), 1);
      repeat (30) @(negedge clk);
      exp_idx = (exp_idx + 1) % 1000;
      check(en_at_rise == 8'h04, "R9 first channel kept", int'(en_at_rise), 4);
      convert(3'd1, 12'h0F0, 0, 1);
      read(at, got);
      check(got == 16'h05A5, "R9 one entry only", int'(got), 16'h05A5);
      read(at + 1, got);
      check(got == 16'h00F0, "R9 next entry adjacent", int'(got), 16'h00F0);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      check(ovr_flag == 1'b0, "R9 overrun clear", int'(ovr_flag), 0);
    end

    // fill to wrap
    while (exp_idx != 999) convert(3'(exp_idx), 12'(exp_idx * 37), 0, 1);
    check(full_flag == 1'b0 && pulse_cnt == 0, "R7 no early wrap", pulse_cnt, 0);
    convert(3'd3, 12'h999, 0, 1);
    check(pulse_cnt == 1, "R7 single wrap pulse", pulse_cnt, 1);
    check(pulse_max == 1, "R7 pulse width", pulse_max, 1);
    check(full_flag == 1'b1, "R8 full sticky", int'(full_flag), 1);
    read(999, got);
    check(got == 16'h0999, "R7 last entry", int'(got), 16'h0999);
    convert(3'd0, 12'hBEE, 0, 1);
    read(0, got);
    check(got == 16'h0BEE, "R7 wrap to zero", int'(got), 16'h0BEE);
    read(1, got);
    check(got == 16'h0FFF, "R6 neighbour untouched", int'(got), 16'h0FFF);
    check(full_flag == 1'b1, "R8 still set", int'(full_flag), 1);
    @(negedge clk); full_ack = 1'b1;
    @(negedge clk); full_ack = 1'b0;
    check(full_flag == 1'b0, "R8 ack clears", int'(full_flag), 0);

    // read port corner cases
    read(1020, got);
    check(got == 16'h0, "R10 out of range", int'(got), 0);
    @(negedge clk);
    rd_rsp_ready = 1'b0; rd_req_valid = 1'b1; rd_addr = 10'd0;
    @(negedge clk);
    rd_req_valid = 1'b0;
    got = rd_rsp_data;
    check(rd_rsp_valid && !rd_req_ready, "R10 backpressure", int'({rd_rsp_valid, rd_req_ready}), 2);
    repeat (3) @(negedge clk);
    check(rd_rsp_valid && rd_rsp_data == got && got == 16'h0BEE, "R10 held data", int'(rd_rsp_data), 16'h0BEE);
    rd_rsp_ready = 1'b1;
    @(negedge clk);
    check(!rd_rsp_valid && rd_req_ready, "R10 drained", int'({rd_rsp_valid, rd_req_ready}), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule